// File: doc/BRIEF.md
# Phit Lane-Width Mapper with Half-Link Failover

This block sits at the transmit edge of a point-to-point link. It takes 20-bit phits through a valid/ready handshake and places them on a 20-lane data bus. The bus is built from four groups of five lanes, and the forwarded clock lane sits logically between the lower half (groups 0 and 1) and the upper half (groups 2 and 3). At full width a phit leaves in one cycle. In the reduced-width modes the unused lanes are switched off, and the phit is cut into 10-bit or 5-bit slices that go out on consecutive cycles, lowest slice first. A per-lane enable tells the lane drivers which lanes are live.

The same width reduction also provides fault tolerance. A hard fault on any data lane takes down the half that holds it, and traffic continues on the other half. A fault on the clock lane also drops the link to half width, and the forwarded clock is moved onto the lowest healthy lane of the half that was turned off. The block samples the width select and the fault inputs only on a phit boundary, so no phit is ever split across two mappings. If faults leave no usable half, or leave no spare lane for the clock, the block raises a sticky error flag. It then stops accepting phits and turns every lane off until reset.

A small receive-side collector (`phit_lane_collector`) infers the mode from the lane enables and rebuilds whole phits. It is provided for use in test.

Top module: `phit_lane_mapper`

## Requirements
- R1: When all 20 lanes are enabled, a valid phit appears unchanged on `lane_data` in the same cycle, and `in_ready` is high in that cycle.
- R2: `lane_en` changes only in whole groups of five. Full width enables all lanes. Half width enables lanes 0–9, or lanes 10–19 when the lower half is disabled. Quarter width enables lanes 0–4, or lanes 10–14 when the lower half is disabled.
- R3: `width_sel` = 1 selects half width. Phit bits [9:0] go out in the first cycle and bits [19:10] in the second, on the ten active lanes in ascending order.
- R4: `width_sel` = 2 or 3 selects quarter width. The four 5-bit slices [4:0], [9:5], [14:10] and [19:15] go out in that order on the five active lanes.
- R5: `in_ready` is high only in the cycle that presents the last slice of the current phit. A phit is accepted when `in_valid` and `in_ready` are both high.
- R6: Every lane whose enable is low drives 0. When `in_valid` is low, all lanes drive 0.
- R7: A fault on any of lanes 0–9 switches the link to half width on lanes 10–19. A fault on any of lanes 10–19 keeps it on lanes 0–9. In both cases a full-width request is served at half width, and a quarter-width request stays at quarter width in the surviving half.
- R8: A clock-lane fault drives `clk_lane_en` low and forces half width. The upper half is turned off unless the lower half is faulty. The clock then moves to the lowest non-faulty lane of the half that was turned off, and `clk_route` marks that lane one-hot. `clk_route` is 0 while the clock lane is healthy.
- R9: Data faults in both halves, or a clock fault with no healthy lane left in the half that was turned off, set `unrec_err` one clock edge later. The flag holds until reset. While it is set, `in_ready`, `lane_en`, `lane_data`, `clk_lane_en` and `clk_route` are all 0.
- R10: The block applies changes on `width_sel`, `lane_fault` and `clk_lane_fault` only at a phit boundary. A boundary is an edge that ends an accepted phit, or an idle edge with no phit in flight. The remaining slices of a phit in flight keep their mapping.
- R11: The collector asserts `rx_valid` with the rebuilt phit in the cycle after the last slice was on the lanes.
- R12: After reset, lanes are at full width with all enables high, `in_ready` = 1, `clk_lane_en` = 1, `clk_route` = 0 and `unrec_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Phit offered; must hold with `in_phit` stable until accepted |
| in_phit | input | 20 | Phit to send |
| in_ready | output | 1 | High on the last slice of the current phit |
| width_sel | input | 2 | Requested width: 0 full, 1 half, 2 or 3 quarter |
| lane_fault | input | 20 | Per-data-lane hard-fault indication |
| clk_lane_fault | input | 1 | Hard fault on the forwarded clock lane |
| lane_data | output | 20 | Data driven onto the lanes |
| lane_en | output | 20 | Per-lane driver enable |
| clk_lane_en | output | 1 | Enable for the dedicated clock lane |
| clk_route | output | 20 | One-hot data lane carrying the relocated clock, 0 if none |
| unrec_err | output | 1 | Sticky unrecoverable fault flag |

## Verification
Lane data, lane enables and `in_ready` follow the inputs and the stored mapping with no register delay. The bench therefore checks each slice in the middle of the cycle that presents it. A new width or fault pattern takes effect after exactly one edge, and only if that edge is a boundary. The bench applies a change in one cycle and checks the new enables in the following cycle, and it also changes inputs in the middle of a phit to show that the second slice keeps its old mapping. The error flag and the collector output each appear one edge after their cause, so the bench checks both the cycle before that edge, where the flag or output is still absent, and the cycle after it.

// File: rtl/lane_map_pkg.sv
package lane_map_pkg;

  typedef enum logic [1:0] {
    WM_FULL    = 2'd0,
    WM_HALF    = 2'd1,
    WM_QUARTER = 2'd2
  } width_e;

  // Number of cycles one phit occupies in a given width mode.
  function automatic int unsigned slices_of(width_e m);
    case (m)
      WM_FULL: return 1;
      WM_HALF: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/lane_cfg_sel.sv
// Derives the mapping the link should use from the width request and faults.
module lane_cfg_sel
  import lane_map_pkg::*;
#(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int HALF  = 2 * GRP_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [1:0]       width_sel,
  input  logic [LANES-1:0] lane_fault,
  input  logic             clk_fault,
  output width_e           mode_o,
  output logic             hi_half_o,
  output logic             clk_moved_o,
  output logic [IDX_W-1:0] clk_idx_o,
  output logic             fatal_o
);

  logic   lo_bad, hi_bad, degraded, spare_found;
  width_e req;

  always_comb begin
    lo_bad   = |lane_fault[HALF-1:0];
    hi_bad   = |lane_fault[LANES-1:HALF];
    degraded = lo_bad | hi_bad | clk_fault;

    case (width_sel)
      2'd0:    req = WM_FULL;
      2'd1:    req = WM_HALF;
      default: req = WM_QUARTER;
    endcase

    // Any failover caps the link at half width.
    mode_o    = (degraded && req == WM_FULL) ? WM_HALF : req;
    hi_half_o = lo_bad;

    // Lowest healthy lane of the switched-off half: scan downward, last hit wins.
    spare_found = 1'b0;
    clk_idx_o   = '0;
    for (int i = HALF - 1; i >= 0; i--) begin
      int lane;
      lane = lo_bad ? i : i + HALF;
      if (!lane_fault[lane]) begin
        spare_found = 1'b1;
        clk_idx_o   = IDX_W'(lane);
      end
    end

    clk_moved_o = clk_fault && spare_found;
    fatal_o     = (lo_bad && hi_bad) || (clk_fault && !spare_found);
  end

endmodule

// File: rtl/lane_seq.sv
// Slice counter, boundary-gated mapping register and sticky error state.
module lane_seq
  import lane_map_pkg::*;
#(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  width_e           mode_d,
  input  logic             hi_half_d,
  input  logic             clk_moved_d,
  input  logic [IDX_W-1:0] clk_idx_d,
  input  logic             fatal_d,
  output width_e           mode_q,
  output logic             hi_half_q,
  output logic             clk_moved_q,
  output logic [IDX_W-1:0] clk_idx_q,
  output logic [1:0]       slice_q,
  output logic             last_o,
  output logic             fatal_q
);

  logic [1:0] slice_nx;
  logic       cfg_en, slice_en, fatal_nx;

  always_comb begin
    last_o   = (slice_q == 2'(slices_of(mode_q) - 1));
    slice_en = in_valid && !fatal_q;
    slice_nx = last_o ? 2'd0 : slice_q + 2'd1;
    // Boundary: a phit completes, or nothing is in flight and nothing is offered.
    cfg_en   = !fatal_q && ((in_valid && last_o) || (!in_valid && slice_q == 2'd0));
    fatal_nx = fatal_q | fatal_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= 2'd0;
    end else if (slice_en) begin
      slice_q <= slice_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= WM_FULL;
      hi_half_q   <= 1'b0;
      clk_moved_q <= 1'b0;
      clk_idx_q   <= '0;
    end else if (cfg_en) begin
      mode_q      <= mode_d;
      hi_half_q   <= hi_half_d;
      clk_moved_q <= clk_moved_d;
      clk_idx_q   <= clk_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
    end else begin
      fatal_q <= fatal_nx;
    end
  end

endmodule

// File: rtl/lane_drive.sv
// Steers the current slice onto the active lanes and forms the enables.
module lane_drive
  import lane_map_pkg::*;
#(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int HALF  = 2 * GRP_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             in_valid,
  input  logic [LANES-1:0] in_phit,
  input  width_e           mode,
  input  logic             hi_half,
  input  logic [1:0]       slice,
  input  logic             clk_moved,
  input  logic [IDX_W-1:0] clk_idx,
  input  logic             fatal,
  output logic [LANES-1:0] lane_data,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] clk_route,
  output logic             clk_lane_en
);

  logic [LANES-1:0] data_raw, en_raw;
  logic [HALF-1:0]  half_slice;
  logic [GRP_W-1:0] q_slice;
  int               base;

  always_comb begin
    base       = hi_half ? HALF : 0;
    half_slice = slice[0] ? in_phit[LANES-1:HALF] : in_phit[HALF-1:0];
    q_slice    = in_phit[int'(slice) * GRP_W +: GRP_W];

    case (mode)
      WM_FULL: begin
        en_raw   = '1;
        data_raw = in_phit;
      end
      WM_HALF: begin
        en_raw   = LANES'({HALF{1'b1}}) << base;
        data_raw = LANES'(half_slice) << base;
      end
      default: begin
        en_raw   = LANES'({GRP_W{1'b1}}) << base;
        data_raw = LANES'(q_slice) << base;
      end
    endcase

    lane_en     = fatal ? '0 : en_raw;
    lane_data   = (in_valid && !fatal) ? data_raw : '0;
    clk_route   = (clk_moved && !fatal) ? (LANES'(1) << clk_idx) : '0;
    clk_lane_en = !fatal && !clk_moved;
  end

endmodule

// File: rtl/phit_lane_collector.sv
// Receive-side reassembly: infers width from the enables and rebuilds phits.
module phit_lane_collector #(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int HALF  = 2 * GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_valid,
  input  logic [LANES-1:0] lane_data,
  input  logic [LANES-1:0] lane_en,
  output logic             rx_valid,
  output logic [LANES-1:0] rx_phit
);

  logic [LANES-1:0] acc_q, acc_d, shifted;
  logic [1:0]       cnt_q;
  logic             last;
  int               nsl, base;

  always_comb begin
    base    = lane_en[0] ? 0 : HALF;
    shifted = lane_data >> base;
    acc_d   = acc_q;
    if ($countones(lane_en) == LANES) begin
      nsl   = 1;
      acc_d = lane_data;
    end else if ($countones(lane_en) == HALF) begin
      nsl = 2;
      if (cnt_q[0]) acc_d[LANES-1:HALF] = shifted[HALF-1:0];
      else          acc_d[HALF-1:0]     = shifted[HALF-1:0];
    end else begin
      nsl = 4;
      acc_d[int'(cnt_q) * GRP_W +: GRP_W] = shifted[GRP_W-1:0];
    end
    last = (cnt_q == 2'(nsl - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      acc_q <= '0;
    end else if (lane_valid) begin
      cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_phit  <= '0;
    end else begin
      rx_valid <= lane_valid && last;
      if (lane_valid && last) rx_phit <= acc_d;
    end
  end

endmodule

// File: rtl/phit_lane_mapper.sv
module phit_lane_mapper
  import lane_map_pkg::*;
#(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_phit,
  output logic             in_ready,
  input  logic [1:0]       width_sel,
  input  logic [LANES-1:0] lane_fault,
  input  logic             clk_lane_fault,
  output logic [LANES-1:0] lane_data,
  output logic [LANES-1:0] lane_en,
  output logic             clk_lane_en,
  output logic [LANES-1:0] clk_route,
  output logic             unrec_err
);

  logic             rst_meta, rst_sync;
  width_e           mode_d, mode_q;
  logic             hi_half_d, hi_half_q, moved_d, moved_q, fatal_d, last;
  logic [IDX_W-1:0] cidx_d, cidx_q;
  logic [1:0]       slice_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lane_cfg_sel #(.GRP_W(GRP_W)) u_cfg (
    .width_sel   (width_sel),
    .lane_fault  (lane_fault),
    .clk_fault   (clk_lane_fault),
    .mode_o      (mode_d),
    .hi_half_o   (hi_half_d),
    .clk_moved_o (moved_d),
    .clk_idx_o   (cidx_d),
    .fatal_o     (fatal_d)
  );

  lane_seq #(.GRP_W(GRP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync),
    .in_valid    (in_valid),
    .mode_d      (mode_d),
    .hi_half_d   (hi_half_d),
    .clk_moved_d (moved_d),
    .clk_idx_d   (cidx_d),
    .fatal_d     (fatal_d),
    .mode_q      (mode_q),
    .hi_half_q   (hi_half_q),
    .clk_moved_q (moved_q),
    .clk_idx_q   (cidx_q),
    .slice_q     (slice_q),
    .last_o      (last),
    .fatal_q     (unrec_err)
  );

  lane_drive #(.GRP_W(GRP_W)) u_drv (
    .in_valid    (in_valid),
    .in_phit     (in_phit),
    .mode        (mode_q),
    .hi_half     (hi_half_q),
    .slice       (slice_q),
    .clk_moved   (moved_q),
    .clk_idx     (cidx_q),
    .fatal       (unrec_err),
    .lane_data   (lane_data),
    .lane_en     (lane_en),
    .clk_route   (clk_route),
    .clk_lane_en (clk_lane_en)
  );

  assign in_ready = last && !unrec_err;

endmodule

// File: rtl/phit_lane_mapper_chk.sv
module phit_lane_mapper_chk #(
  parameter  int GRP_W = 5,
  localparam int LANES = 4 * GRP_W,
  localparam int HALF  = 2 * GRP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] lane_data,
  input logic [LANES-1:0] lane_en,
  input logic             clk_lane_en,
  input logic [LANES-1:0] clk_route,
  input logic             unrec_err
);

  AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_en) == LANES) |-> in_ready); // R1

  for (genvar g = 0; g < 4; g++) begin : g_grp
    AST_GROUP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[g*GRP_W +: GRP_W] == '0) || (lane_en[g*GRP_W +: GRP_W] == '1)); // R2
  end

  AST_HALF_SECOND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !unrec_err && $countones(lane_en) == HALF)
      |=> (in_ready || unrec_err)); // R5

  AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_data & ~lane_en) == '0); // R6

  AST_CLK_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_route != '0) |-> ($onehot(clk_route) && !clk_lane_en && (clk_route & lane_en) == '0)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unrec_err |=> unrec_err); // R9

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    unrec_err |-> (!in_ready && lane_en == '0 && clk_route == '0)); // R9

  AST_MIDPHIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !unrec_err) |=> ($stable(lane_en) || unrec_err)); // R10

endmodule

bind phit_lane_mapper phit_lane_mapper_chk #(.GRP_W(GRP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lane_data   (lane_data),
  .lane_en     (lane_en),
  .clk_lane_en (clk_lane_en),
  .clk_route   (clk_route),
  .unrec_err   (unrec_err)
);

// File: tb/phit_lane_mapper_bench.sv
module phit_lane_mapper_bench;

  logic        clk, rst_n, in_valid, in_ready, clk_lane_fault;
  logic        clk_lane_en, unrec_err, rx_valid;
  logic [19:0] in_phit, lane_fault, lane_data, lane_en, clk_route, rx_phit;
  logic [1:0]  width_sel;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  phit_lane_mapper u_phit_lane_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phit(in_phit),
    .in_ready(in_ready), .width_sel(width_sel), .lane_fault(lane_fault),
    .clk_lane_fault(clk_lane_fault), .lane_data(lane_data), .lane_en(lane_en),
    .clk_lane_en(clk_lane_en), .clk_route(clk_route), .unrec_err(unrec_err)
  );

  phit_lane_collector u_rx (
    .clk(clk), .rst_n(rst_n), .lane_valid(in_valid & ~unrec_err),
    .lane_data(lane_data), .lane_en(lane_en), .rx_valid(rx_valid), .rx_phit(rx_phit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_phit = '0; width_sel = 2'd0;
    lane_fault = '0; clk_lane_fault = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  // Apply a mapping while idle; it is in force after one edge.
  task automatic set_cfg(logic [1:0] w, logic [19:0] f, logic cf);
    width_sel = w; lane_fault = f; clk_lane_fault = cf;
    step();
  endtask

  // Sends one phit and checks each slice plus the rebuilt phit.
  task automatic send_phit(string req, logic [19:0] p, int nsl, int base);
    logic [31:0] exp;
    in_valid = 1'b1; in_phit = p;
    for (int k = 0; k < nsl; k++) begin
      @(negedge clk);
      if (nsl == 1)      exp = 32'(p);
      else if (nsl == 2) exp = ((32'(p) >> (10 * k)) & 32'h3ff) << base;
      else               exp = ((32'(p) >> (5 * k)) & 32'h1f) << base;
      chk(req, $sformatf("slice %0d data", k), 32'(lane_data), exp);
      chk("R5", $sformatf("ready on slice %0d", k), 32'(in_ready), 32'(k == nsl - 1));
      step();
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11", "rx_valid", 32'(rx_valid), 32'd1);
    chk("R11", "rx_phit", 32'(rx_phit), 32'(p));
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "lane_en", 32'(lane_en), 32'hfffff);
    chk("R12", "in_ready", 32'(in_ready), 32'd1);
    chk("R12", "unrec_err", 32'(unrec_err), 32'd0);
    chk("R12", "clk_lane_en", 32'(clk_lane_en), 32'd1);
    chk("R12", "clk_route", 32'(clk_route), 32'd0);
    chk("R6", "idle data", 32'(lane_data), 32'd0);
    step();
  endtask

  task automatic t_full();
    send_phit("R1", 20'h12345, 1, 0);
    send_phit("R1", 20'habcde, 1, 0);
    send_phit("R1", 20'hfffff, 1, 0);
    @(negedge clk);
    chk("R2", "full enables", 32'(lane_en), 32'hfffff);
    step();
  endtask

  task automatic t_half();
    set_cfg(2'd1, '0, 1'b0);
    @(negedge clk);
    chk("R2", "half enables", 32'(lane_en), 32'h003ff);
    step();
    send_phit("R3", 20'h9a5c3, 2, 0);
  endtask

  task automatic t_quarter();
    set_cfg(2'd2, '0, 1'b0);
    @(negedge clk);
    chk("R2", "quarter enables", 32'(lane_en), 32'h0001f);
    step();
    send_phit("R4", 20'h7b1e4, 4, 0);
    set_cfg(2'd3, '0, 1'b0);
    in_phit = 20'hfffff;
    @(negedge clk);
    chk("R6", "data with valid low", 32'(lane_data), 32'd0);
    step();
    send_phit("R4", 20'h5c3a1, 4, 0);
  endtask

  task automatic t_fault_data();
    set_cfg(2'd0, 20'h00008, 1'b0);
    @(negedge clk);
    chk("R7", "lower fault enables", 32'(lane_en), 32'hffc00);
    chk("R7", "clk_route", 32'(clk_route), 32'd0);
    step();
    send_phit("R7", 20'h3c96a, 2, 10);
    set_cfg(2'd2, 20'h08000, 1'b0);
    @(negedge clk);
    chk("R7", "upper fault quarter enables", 32'(lane_en), 32'h0001f);
    step();
    send_phit("R7", 20'he4d21, 4, 0);
    set_cfg(2'd2, 20'h00010, 1'b0);
    @(negedge clk);
    chk("R2", "quarter in upper half", 32'(lane_en), 32'h07c00);
    step();
    send_phit("R7", 20'h2b7f0, 4, 10);
  endtask

  task automatic t_clock();
    set_cfg(2'd0, '0, 1'b1);
    @(negedge clk);
    chk("R8", "clk_lane_en", 32'(clk_lane_en), 32'd0);
    chk("R8", "route lane 10", 32'(clk_route), 32'h00400);
    chk("R8", "half enables", 32'(lane_en), 32'h003ff);
    step();
    set_cfg(2'd0, 20'h00400, 1'b1);
    @(negedge clk);
    chk("R8", "route skips faulty lane 10", 32'(clk_route), 32'h00800);
    step();
    set_cfg(2'd0, 20'h00001, 1'b1);
    @(negedge clk);
    chk("R8", "route lane 1", 32'(clk_route), 32'h00002);
    chk("R8", "upper enables", 32'(lane_en), 32'hffc00);
    step();
    send_phit("R8", 20'h6d5b9, 2, 10);
  endtask

  task automatic t_boundary();
    set_cfg(2'd1, '0, 1'b0);
    in_valid = 1'b1; in_phit = 20'h4f1a7;
    @(negedge clk);
    chk("R10", "slice 0 data", 32'(lane_data), 32'h001a7 & 32'h3ff);
    width_sel = 2'd0;
    step();
    @(negedge clk);
    chk("R10", "enables held mid-phit", 32'(lane_en), 32'h003ff);
    chk("R10", "slice 1 data", 32'(lane_data), 32'h0013c);
    step();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "full after boundary", 32'(lane_en), 32'hfffff);
    step();
    set_cfg(2'd1, '0, 1'b0);
    in_valid = 1'b1; in_phit = 20'h8c2e5;
    @(negedge clk);
    lane_fault = 20'h00010;
    step();
    @(negedge clk);
    chk("R10", "fault held mid-phit enables", 32'(lane_en), 32'h003ff);
    chk("R10", "fault held mid-phit data", 32'(lane_data), 32'h00230);
    step();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "failover after boundary", 32'(lane_en), 32'hffc00);
    step();
  endtask

  task automatic t_fatal();
    set_cfg(2'd0, '0, 1'b0);
    lane_fault = 20'h01004;
    @(negedge clk);
    chk("R9", "flag before edge", 32'(unrec_err), 32'd0);
    step();
    in_valid = 1'b1; in_phit = 20'hfffff;
    @(negedge clk);
    chk("R9", "flag set", 32'(unrec_err), 32'd1);
    chk("R9", "ready low", 32'(in_ready), 32'd0);
    chk("R9", "enables low", 32'(lane_en), 32'd0);
    chk("R9", "data low", 32'(lane_data), 32'd0);
    chk("R9", "clock lane off", 32'(clk_lane_en), 32'd0);
    step();
    in_valid = 1'b0; lane_fault = '0;
    repeat (3) step();
    @(negedge clk);
    chk("R9", "flag sticky", 32'(unrec_err), 32'd1);
    step();
    do_reset();
    @(negedge clk);
    chk("R12", "flag cleared by reset", 32'(unrec_err), 32'd0);
    chk("R12", "enables after reset", 32'(lane_en), 32'hfffff);
    step();
    lane_fault = 20'hffc00; clk_lane_fault = 1'b1;
    step();
    @(negedge clk);
    chk("R9", "no spare for clock", 32'(unrec_err), 32'd1);
    chk("R9", "no route when failed", 32'(clk_route), 32'd0);
    step();
    do_reset();
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset();
        t_full();
        t_half();
        t_quarter();
        t_fault_data();
        t_clock();
        t_boundary();
        t_fatal();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual=running expected=finished");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule